// File: doc/BRIEF.md
# Tunable Watchdog Timebase with Oscillator Calibration

The block makes the slow tick that paces a watchdog. A 10 kHz enable is divided by a 12-bit programmable divisor into a tick of about 10 Hz. Software can trim the divisor because the block also has a calibration meter. The meter counts cycles of the fast system clock across ten periods of a 500 kHz internal-oscillator enable. From that result software can work out how fast the slow oscillators really run.

Three byte-wide registers at indices 29h, 2Ah and 2Bh expose the divisor, the start strobe and the measured count. They answer only while the program-enable input is high. While it is low, the window reads zero and drops every write. Both oscillators arrive as single-cycle enables in the system clock domain.

Top module: `wdt_timebase`

## Requirements
- R1: After reset the divisor is 12'h3E7 and tick_o is low. Index 29h reads 8'h03, index 2Ah reads 8'hE7 and index 2Bh reads 8'h00.
- R2: tick_o rises once every divisor+1 pulses of en_10k_i (1000 at reset). It stays high for exactly one en_10k_i period.
- R3: A new divisor value takes effect at the next counter wrap. The interval that is running when the value is written keeps its old length.
- R4: With program enable high, index 29h bits 3..0 hold divisor bits 11..8 and index 2Ah holds divisor bits 7..0. Bits 6..4 of 29h read 0. Bit 7 of 29h is write-only and reads 0.
- R5: With program enable low, indices 29h, 2Ah and 2Bh read 8'h00. Writes to them change neither the divisor nor the meter, and they start no measurement.
- R6: Writing 1 to bit 7 of index 29h starts a measurement. Counting begins at the first en_500k_i pulse after the write. The result equals the number of clk_i cycles spanning the next ten en_500k_i periods.
- R7: After a start, index 2Ah returns count bits 7..0 instead of the divisor low byte until the next write to 2Ah. Index 2Bh returns count bits 15..8.
- R8: A start written while a measurement is running is ignored. The running measurement continues unchanged.
- R9: The count saturates at 16'hFFFF and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock (48 MHz domain) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_en_i | input | 1 | Opens the calibration register window |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| en_500k_i | input | 1 | Single-cycle enable at the 500 kHz oscillator rate |
| en_10k_i | input | 1 | Single-cycle enable at the 10 kHz oscillator rate |
| tick_o | output | 1 | Watchdog timebase tick |

## Verification
The assertions check the following on every cycle. tick_o changes only after an en_10k_i pulse. The reserved and write-only bits of 29h read zero. The closed window reads zero and leaves the divisor untouched. A running count never decreases and holds once it saturates. The bench scenarios cover what only needs a sequence of events to show. These are the exact tick period before and after a divisor change, the wrap-aligned switchover, the exact ten-period count, the result view and its release, a second start being ignored, and saturation on a slow oscillator.

// File: rtl/wdt_timebase_pkg.sv
package wdt_timebase_pkg;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] IDX_DIV_HI = 8'h29;
  localparam logic [AW-1:0] IDX_DIV_LO = 8'h2A;
  localparam logic [AW-1:0] IDX_CNT_HI = 8'h2B;

  typedef enum logic [1:0] {
    MEAS_IDLE = 2'd0,
    MEAS_ARM  = 2'd1,
    MEAS_RUN  = 2'd2
  } meas_state_e;
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int unsigned DIV_W = 12,
  parameter logic [DIV_W-1:0] DIV_RST = 12'h3E7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, act_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (cnt_q == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= DIV_RST;
      tick_q <= 1'b0;
    end else if (en_i) begin
      tick_q <= wrap;
      if (wrap) begin
        cnt_q <= '0;
        act_q <= div_i;  // new divisor only at a wrap
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/wdt_cal_meter.sv
module wdt_cal_meter
  import wdt_timebase_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PERIODS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             osc_en_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned EW = $clog2(PERIODS + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(PERIODS - 1);

  meas_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MEAS_IDLE;
      cnt_q  <= '0;
      edge_q <= '0;
    end else begin
      case (st_q)
        MEAS_IDLE: if (start_i) begin
          st_q   <= MEAS_ARM;
          cnt_q  <= '0;
          edge_q <= '0;
        end
        MEAS_ARM: if (osc_en_i) st_q <= MEAS_RUN;  // align to an oscillator edge
        MEAS_RUN: begin
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
          if (osc_en_i) begin
            if (edge_q == LAST_EDGE) st_q <= MEAS_IDLE;
            else edge_q <= edge_q + 1'b1;
          end
        end
        default: st_q <= MEAS_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != MEAS_IDLE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_timebase_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 12,
  parameter int unsigned CNT_W = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 12'h3E7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [DIV_W-1:0] div_o,
  output logic             start_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int unsigned HI_W = DIV_W - DW;

  logic [DIV_W-1:0] div_q;
  logic             view_q;
  logic             wr_hi, wr_lo;

  assign wr_hi   = prog_en_i && we_i && (addr_i == IDX_DIV_HI);
  assign wr_lo   = prog_en_i && we_i && (addr_i == IDX_DIV_LO);
  assign start_o = wr_hi && wdata_i[DW-1] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_RST;
      view_q <= 1'b0;
    end else begin
      if (wr_hi) div_q[DIV_W-1:DW] <= wdata_i[HI_W-1:0];
      if (wr_lo) div_q[DW-1:0]     <= wdata_i;
      if (start_o)    view_q <= 1'b1;
      else if (wr_lo) view_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (prog_en_i) begin
      case (addr_i)
        IDX_DIV_HI: rdata_o = {{(DW-HI_W){1'b0}}, div_q[DIV_W-1:DW]};
        IDX_DIV_LO: rdata_o = view_q ? cnt_i[DW-1:0] : div_q[DW-1:0];
        IDX_CNT_HI: rdata_o = cnt_i[CNT_W-1:DW];
        default:    rdata_o = '0;
      endcase
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_timebase_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned DIV_W   = 12,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PERIODS = 10,
  parameter logic [DIV_W-1:0] DIV_RST = 12'h3E7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          en_500k_i,
  input  logic          en_10k_i,
  output logic          tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] meas_cnt;
  logic             busy, start;

  wdt_regs #(.DW(DW), .DIV_W(DIV_W), .CNT_W(CNT_W), .DIV_RST(DIV_RST)) u_regs (
    .clk_i, .rst_ni, .prog_en_i, .we_i, .addr_i, .wdata_i,
    .busy_i(busy), .cnt_i(meas_cnt), .div_o(div_q), .start_o(start), .rdata_o
  );

  wdt_cal_meter #(.CNT_W(CNT_W), .PERIODS(PERIODS)) u_meter (
    .clk_i, .rst_ni, .start_i(start), .osc_en_i(en_500k_i),
    .busy_o(busy), .cnt_o(meas_cnt)
  );

  wdt_tick_div #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
    .clk_i, .rst_ni, .en_i(en_10k_i), .div_i(div_q), .tick_o
  );
endmodule

// File: rtl/wdt_timebase_chk.sv
module wdt_timebase_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 12,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prog_en_i,
  input logic             we_i,
  input logic [7:0]       addr_i,
  input logic [DW-1:0]    rdata_o,
  input logic             en_10k_i,
  input logic             tick_o,
  input logic [DIV_W-1:0] div_q,
  input logic             busy,
  input logic [CNT_W-1:0] meas_cnt
);
  p_tick_on_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tick_o) |-> $past(en_10k_i));

  p_hi_reserved_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h29) |-> (rdata_o[DW-1:DW-4] == '0));

  p_window_closed_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_i && addr_i >= 8'h29 && addr_i <= 8'h2B) |-> (rdata_o == '0));

  p_window_closed_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_i && we_i) |=> $stable(div_q));

  p_count_monotonic_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (meas_cnt >= $past(meas_cnt)) || (meas_cnt == '0));

  p_count_saturates_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && meas_cnt == '1) |=> (meas_cnt == '1));
endmodule

bind wdt_timebase wdt_timebase_chk #(.DW(DW), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prog_en_i(prog_en_i), .we_i(we_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .en_10k_i(en_10k_i), .tick_o(tick_o),
  .div_q(div_q), .busy(busy), .meas_cnt(meas_cnt)
);

// File: tb/sim_wdt_timebase.sv
module sim_wdt_timebase;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       prog_en_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0, rdata_o;
  logic       en_500k_i = 1'b0, en_10k_i = 1'b0, tick_o;

  int checks = 0, errors = 0;
  int cyc = 0, per10 = 2, per500 = 96, ph10 = 0, ph500 = 0;
  int rise_cnt = 0, last_rise = 0, hi_len = 0, last_hi = 0;
  logic tick_prev = 1'b0;

  wdt_timebase u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    cyc++;
    en_10k_i  <= (ph10 == 0);
    ph10       = (ph10 >= per10 - 1) ? 0 : ph10 + 1;
    en_500k_i <= (ph500 == 0);
    ph500      = (ph500 >= per500 - 1) ? 0 : ph500 + 1;
    if (tick_o && !tick_prev) begin rise_cnt++; last_rise = cyc; end
    if (tick_o) hi_len++;
    else if (tick_prev) begin last_hi = hi_len; hi_len = 0; end
    tick_prev = tick_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic wait_rise(output int at);
    int n = rise_cnt;
    while (rise_cnt == n) begin @(negedge clk_i); #1; end
    at = last_rise;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    int v;
    prog_en_i = 1'b1;
    rd(8'h29, v); chk("R1 idx29", v, 8'h03);
    rd(8'h2A, v); chk("R1 idx2A", v, 8'hE7);
    rd(8'h2B, v); chk("R1 idx2B", v, 8'h00);
    chk("R1 tick low", int'(tick_o), 0);
  endtask

  task automatic t_fields;
    int v;
    wr(8'h29, 8'h7F);
    rd(8'h29, v); chk("R4 reserved/write-only bits", v, 8'h0F);
    wr(8'h29, 8'h03);
    rd(8'h29, v); chk("R4 high nibble", v, 8'h03);
  endtask

  task automatic t_closed;
    int v;
    prog_en_i = 1'b0;
    rd(8'h29, v); chk("R5 idx29 closed", v, 0);
    rd(8'h2A, v); chk("R5 idx2A closed", v, 0);
    rd(8'h2B, v); chk("R5 idx2B closed", v, 0);
    wr(8'h2A, 8'h10);
    wr(8'h29, 8'h81);
    prog_en_i = 1'b1;
    rd(8'h2A, v); chk("R5 low byte kept, no start", v, 8'hE7);
    rd(8'h29, v); chk("R5 high nibble kept", v, 8'h03);
  endtask

  task automatic t_period;
    int a, b, c, d;
    wait_rise(a);
    wait_rise(b);
    chk("R2 reset period", b - a, 1000 * per10);
    chk("R2 tick high width", last_hi, per10);
    wr(8'h29, 8'h00);
    wr(8'h2A, 8'h04);
    wait_rise(c);
    chk("R3 running interval keeps old divisor", c - b, 1000 * per10);
    wait_rise(d);
    chk("R3 new divisor after wrap", d - c, 5 * per10);
    wait_rise(a);
    chk("R2 programmed period", a - d, 5 * per10);
    chk("R2 tick high width div4", last_hi, per10);
  endtask

  task automatic t_measure;
    int lo, hi;
    per500 = 96;
    wr(8'h29, 8'h80);
    idle(1200);
    rd(8'h2A, lo); rd(8'h2B, hi);
    chk("R6 ten periods count", hi * 256 + lo, 960);
    chk("R7 count low in 2A", lo, 8'hC0);
    wr(8'h2A, 8'h04);
    rd(8'h2A, lo); chk("R7 view released by 2A write", lo, 8'h04);
  endtask

  task automatic t_busy_restart;
    int lo, hi;
    per500 = 50;
    wr(8'h29, 8'h80);
    idle(300);
    wr(8'h29, 8'h80);
    idle(400);
    rd(8'h2A, lo); rd(8'h2B, hi);
    chk("R8 restart while busy ignored", hi * 256 + lo, 500);
  endtask

  task automatic t_saturate;
    int lo, hi;
    per500 = 7000;
    wr(8'h29, 8'h80);
    idle(7000 * 11 + 500);
    rd(8'h2A, lo); rd(8'h2B, hi);
    chk("R9 saturation", hi * 256 + lo, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fields();
    t_closed();
    t_period();
    t_measure();
    t_busy_restart();
    t_saturate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule